// File: doc/BRIEF.md
# AHB Wait-State Rule Monitor

This block is a passive observer for an AHB-Lite bus. Each clock it compares the transfer type and address the manager presents with what it presented one cycle earlier. When the earlier cycle was stalled (HREADY low), it checks that any change is one the protocol allows. Which changes are allowed depends on three things: the kind of burst in progress (fixed length or undefined length), whether the stalled beat was IDLE, BUSY or an active transfer, and whether an ERROR response has opened an exemption window.

It drives no bus signal. Each broken rule sets its own sticky flag, and a single-cycle violation pulse marks every offending sample. The monitor can be left in silicon as a debug aid or bound into a simulation environment beside a manager model.

Top module: `ahbw_wait_monitor`

## Requirements
- R1: After reset, and until an offending sample, `flag_type`, `flag_addr`, `flag_seq` and `viol_pulse` are all 0.
- R2: HTRANS is encoded IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. In a fixed-length burst, a stalled BUSY may stay BUSY or become SEQ. Becoming IDLE or NONSEQ on the next cycle sets `flag_type`.
- R3: In an undefined-length burst (HBURST 000 or 001), a stalled BUSY may become any transfer type without any flag.
- R4: A stalled NONSEQ or SEQ must keep its type. Any change on the next cycle sets `flag_type`.
- R5: A stalled NONSEQ or SEQ must keep its address. A change sets `flag_addr`.
- R6: While stalled, a BUSY beat may change its address at most MAX_ADDR_CHG times (default 1). The next change sets `flag_addr`. The count returns to zero on every cycle in which HREADY is sampled high.
- R7: While a stalled beat is IDLE, its address and type may change freely. This includes moving to NONSEQ at a new address.
- R8: When HRESP is sampled high while HREADY is low, type and address changes raise no flag until HREADY is next sampled high.
- R9: A SEQ that directly follows a BUSY must present the BUSY's address. A different address sets `flag_seq`, whether or not the bus was stalled.
- R10: Each flag stays set until reset. `viol_pulse` is high for exactly the one cycle after each offending sample.
- R11: The burst kind is taken from HBURST only when a NONSEQ is accepted (HREADY high). HBURST values 010 to 111 count as fixed length, and HBURST on later beats is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| htrans | input | 2 | Transfer type seen on the bus |
| haddr | input | ADDR_W | Address seen on the bus |
| hburst | input | 3 | Burst type seen on the bus |
| hready | input | 1 | Transfer-done signal seen on the bus |
| hresp | input | 1 | Error response seen on the bus |
| viol_pulse | output | 1 | One-cycle pulse for each offending sample |
| flag_type | output | 1 | Sticky: illegal type change while stalled |
| flag_addr | output | 1 | Sticky: illegal address change while stalled |
| flag_seq | output | 1 | Sticky: SEQ address differs from the preceding BUSY |

## Verification
Every verdict is formed at the clock edge that samples the offending beat. It is registered there, so flags and pulse are due one cycle after the stimulus. The driver applies each beat on the falling edge and queues the flags and pulse expected for that beat. The monitor takes the next entry 1 ns after the following rising edge, so each comparison lands exactly in the cycle the result is due.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam int unsigned NRULE   = 3;
   localparam int unsigned RULE_TY = 0;
   localparam int unsigned RULE_AD = 1;
   localparam int unsigned RULE_SQ = 2;

   function automatic logic burst_is_fixed(input logic [2:0] kind);
      return kind[2] | kind[1];
   endfunction

endpackage

// File: rtl/ahbw_history.sv
module ahbw_history
   import ahbw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 2,
   parameter int unsigned CNT_MAX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        htrans,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [2:0]        hburst,
   input  logic              hready,
   input  logic              hresp,
   input  logic              chg_counted,
   output trans_e            prev_trans,
   output logic [ADDR_W-1:0] prev_addr,
   output logic              prev_ready,
   output logic              burst_fixed,
   output logic              err_win,
   output logic [CNT_W-1:0]  chg_cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_trans  <= TR_IDLE;
         prev_addr   <= '0;
         prev_ready  <= 1'b1;
      end else begin
         prev_trans  <= trans_e'(htrans);
         prev_addr   <= haddr;
         prev_ready  <= hready;
      end
   end

   // burst kind captured only at an accepted NONSEQ
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_fixed <= 1'b0;
      end else if (hready && (htrans == TR_NSEQ)) begin
         burst_fixed <= burst_is_fixed(hburst);
      end
   end

   // error window: opens on HRESP during a stall, closes at HREADY high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_win <= 1'b0;
      end else if (hready) begin
         err_win <= 1'b0;
      end else if (hresp) begin
         err_win <= 1'b1;
      end
   end

   // saturating per-stall address change counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_cnt <= '0;
      end else if (hready) begin
         chg_cnt <= '0;
      end else if (chg_counted && (chg_cnt != CNT_W'(CNT_MAX))) begin
         chg_cnt <= chg_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ahbw_rules.sv
module ahbw_rules
   import ahbw_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned CNT_W           = 2,
   parameter int unsigned MAX_ADDR_CHG    = 1,
   parameter bit          EXEMPT_ON_ERROR = 1'b1
) (
   input  logic [1:0]        htrans,
   input  logic [ADDR_W-1:0] haddr,
   input  trans_e            prev_trans,
   input  logic [ADDR_W-1:0] prev_addr,
   input  logic              prev_ready,
   input  logic              burst_fixed,
   input  logic              err_win,
   input  logic [CNT_W-1:0]  chg_cnt,
   output logic [NRULE-1:0]  hit,
   output logic              chg_counted
);

   logic exempt;
   logic stalled;
   logic addr_moved;
   logic prev_active;
   logic type_bad;

   generate
      if (EXEMPT_ON_ERROR) begin : g_exempt
         assign exempt = err_win;
      end else begin : g_strict
         assign exempt = 1'b0;
      end
   endgenerate

   assign stalled     = !prev_ready && !exempt;
   assign addr_moved  = (haddr != prev_addr);
   assign prev_active = (prev_trans == TR_NSEQ) || (prev_trans == TR_SEQ);

   always_comb begin
      type_bad = 1'b0;
      if (stalled) begin
         unique case (prev_trans)
            TR_BUSY: type_bad = burst_fixed &&
                                (htrans != TR_BUSY) && (htrans != TR_SEQ);
            TR_NSEQ,
            TR_SEQ:  type_bad = (htrans != prev_trans);
            default: type_bad = 1'b0;
         endcase
      end
   end

   assign chg_counted = stalled && (prev_trans != TR_IDLE) && addr_moved;

   assign hit[RULE_TY] = type_bad;
   assign hit[RULE_AD] = chg_counted &&
                         (prev_active || (chg_cnt >= CNT_W'(MAX_ADDR_CHG)));
   assign hit[RULE_SQ] = (prev_trans == TR_BUSY) && (htrans == TR_SEQ) && addr_moved;

endmodule

// File: rtl/ahbw_flags.sv
module ahbw_flags
   import ahbw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NRULE-1:0] hit,
   output logic [NRULE-1:0] sticky,
   output logic             pulse
);

   generate
      for (genvar i = 0; i < NRULE; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sticky[i] <= 1'b0;
            end else if (hit[i]) begin
               sticky[i] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
      end else begin
         pulse <= |hit;
      end
   end

endmodule

// File: rtl/ahbw_wait_monitor.sv
module ahbw_wait_monitor
   import ahbw_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned MAX_ADDR_CHG    = 1,
   parameter bit          EXEMPT_ON_ERROR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        htrans,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [2:0]        hburst,
   input  logic              hready,
   input  logic              hresp,
   output logic              viol_pulse,
   output logic              flag_type,
   output logic              flag_addr,
   output logic              flag_seq
);

   localparam int unsigned CNT_MAX = MAX_ADDR_CHG + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ahbw_wait_monitor: ADDR_W must be at least 2");
      end
      if (MAX_ADDR_CHG < 1) begin : g_bad_max_chg
         $error("ahbw_wait_monitor: MAX_ADDR_CHG must be at least 1");
      end
   endgenerate

   trans_e              prev_trans;
   logic [ADDR_W-1:0]   prev_addr;
   logic                prev_ready;
   logic                burst_fixed;
   logic                err_win;
   logic [CNT_W-1:0]    chg_cnt;
   logic                chg_counted;
   logic [NRULE-1:0]    hit;
   logic [NRULE-1:0]    sticky;

   ahbw_history #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .CNT_MAX(CNT_MAX)
   ) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .htrans     (htrans),
      .haddr      (haddr),
      .hburst     (hburst),
      .hready     (hready),
      .hresp      (hresp),
      .chg_counted(chg_counted),
      .prev_trans (prev_trans),
      .prev_addr  (prev_addr),
      .prev_ready (prev_ready),
      .burst_fixed(burst_fixed),
      .err_win    (err_win),
      .chg_cnt    (chg_cnt)
   );

   ahbw_rules #(
      .ADDR_W         (ADDR_W),
      .CNT_W          (CNT_W),
      .MAX_ADDR_CHG   (MAX_ADDR_CHG),
      .EXEMPT_ON_ERROR(EXEMPT_ON_ERROR)
   ) u_rules (
      .htrans     (htrans),
      .haddr      (haddr),
      .prev_trans (prev_trans),
      .prev_addr  (prev_addr),
      .prev_ready (prev_ready),
      .burst_fixed(burst_fixed),
      .err_win    (err_win),
      .chg_cnt    (chg_cnt),
      .hit        (hit),
      .chg_counted(chg_counted)
   );

   ahbw_flags u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .sticky(sticky),
      .pulse (viol_pulse)
   );

   assign flag_type = sticky[RULE_TY];
   assign flag_addr = sticky[RULE_AD];
   assign flag_seq  = sticky[RULE_SQ];

endmodule

// File: rtl/ahbw_wait_props.sv
module ahbw_wait_props #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        htrans,
   input logic [ADDR_W-1:0] haddr,
   input logic              hready,
   input logic              hresp,
   input logic              viol_pulse,
   input logic              flag_type,
   input logic              flag_addr,
   input logic              flag_seq
);

   logic [2:0] flags;
   logic       chk_err;

   assign flags = {flag_seq, flag_addr, flag_type};

   // independent observation of the error window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chk_err <= 1'b0;
      else if (hready) chk_err <= 1'b0;
      else if (hresp)  chk_err <= 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (flags == 3'b000) && !viol_pulse);

   assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != 3'b000) |=> ((flags & $past(flags)) == $past(flags)));

   assert_pulse_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (flags != 3'b000));

   assert_type_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && !hresp && !chk_err && htrans == 2'b10) ##1 (htrans == 2'b11)
      |=> flag_type);

   assert_nonseq_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && !hresp && !chk_err && htrans == 2'b10) ##1 (haddr != $past(haddr))
      |=> flag_addr);

   assert_seq_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b01) ##1 (htrans == 2'b11 && haddr != $past(haddr))
      |=> flag_seq);

endmodule

bind ahbw_wait_monitor ahbw_wait_props #(.ADDR_W(ADDR_W)) u_props (
   .clk       (clk),
   .rst_n     (rst_n),
   .htrans    (htrans),
   .haddr     (haddr),
   .hready    (hready),
   .hresp     (hresp),
   .viol_pulse(viol_pulse),
   .flag_type (flag_type),
   .flag_addr (flag_addr),
   .flag_seq  (flag_seq)
);

// File: tb/ahbw_wait_monitor_tb_top.sv
`timescale 1ns/1ps
module ahbw_wait_monitor_tb_top;

   localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
   localparam logic [2:0] B_SINGLE = 3'b000, B_INCR = 3'b001, B_INCR4 = 3'b011;
   localparam logic [2:0] H_NONE = 3'b000, H_TY = 3'b001, H_AD = 3'b010, H_SQ = 3'b100;

   typedef struct {
      logic       pulse;
      logic [2:0] flags;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  htrans = IDL;
   logic [31:0] haddr = '0;
   logic [2:0]  hburst = B_SINGLE;
   logic        hready = 1'b1;
   logic        hresp = 1'b0;
   logic        viol_pulse, flag_type, flag_addr, flag_seq;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [2:0]  exp_flags = '0;
   exp_t        sb_q[$];

   always #4 clk = ~clk;

   ahbw_wait_monitor dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .htrans    (htrans),
      .haddr     (haddr),
      .hburst    (hburst),
      .hready    (hready),
      .hresp     (hresp),
      .viol_pulse(viol_pulse),
      .flag_type (flag_type),
      .flag_addr (flag_addr),
      .flag_seq  (flag_seq)
   );

   task automatic beat(input logic [1:0] tr, input logic [31:0] a, input logic [2:0] b,
                       input logic rdy, input logic rsp, input logic [2:0] hit,
                       input string req);
      exp_t e;
      @(negedge clk);
      htrans = tr; haddr = a; hburst = b; hready = rdy; hresp = rsp;
      exp_flags = exp_flags | hit;
      e.pulse = (hit != 3'b000);
      e.flags = exp_flags;
      e.req   = req;
      sb_q.push_back(e);
   endtask

   task automatic restart();
      wait (sb_q.size() == 0);
      @(negedge clk);
      rst_n = 1'b0; htrans = IDL; haddr = '0; hburst = B_SINGLE; hready = 1'b1; hresp = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_flags = '0;
      beat(IDL, 32'h0, B_SINGLE, 1'b1, 1'b0, H_NONE, "R1");
   endtask

   // monitor: one queued expectation per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            logic [2:0] got;
            e = sb_q.pop_front();
            got = {flag_seq, flag_addr, flag_type};
            checks++;
            if (got !== e.flags || viol_pulse !== e.pulse) begin
               errors++;
               $display("FAIL %s: flags=%b pulse=%b expected flags=%b pulse=%b",
                        e.req, got, viol_pulse, e.flags, e.pulse);
            end
         end
      end
   end

   initial begin
      restart();
      // legal fixed burst with BUSY turning into SEQ (R2)
      beat(NSQ, 32'h20, B_INCR4, 1, 0, H_NONE, "R2");
      beat(SQ,  32'h24, B_INCR4, 1, 0, H_NONE, "R2");
      beat(BSY, 32'h28, B_INCR4, 0, 0, H_NONE, "R2");
      beat(BSY, 32'h28, B_INCR4, 0, 0, H_NONE, "R2");
      beat(SQ,  32'h28, B_INCR4, 0, 0, H_NONE, "R2");
      beat(SQ,  32'h28, B_INCR4, 0, 0, H_NONE, "R2");
      beat(SQ,  32'h28, B_INCR4, 1, 0, H_NONE, "R2");
      beat(SQ,  32'h2C, B_INCR4, 1, 0, H_NONE, "R2");
      beat(IDL, 32'h0,  B_SINGLE, 1, 0, H_NONE, "R2");

      // undefined burst, BUSY turning into NONSEQ at new address (R3)
      restart();
      beat(NSQ, 32'h60, B_INCR,  1, 0, H_NONE, "R3");
      beat(SQ,  32'h64, B_INCR,  1, 0, H_NONE, "R3");
      beat(BSY, 32'h68, B_INCR,  0, 0, H_NONE, "R3");
      beat(BSY, 32'h68, B_INCR,  0, 0, H_NONE, "R3");
      beat(NSQ, 32'h10, B_INCR4, 0, 0, H_NONE, "R3");
      beat(NSQ, 32'h10, B_INCR4, 0, 0, H_NONE, "R3");
      beat(NSQ, 32'h10, B_INCR4, 1, 0, H_NONE, "R3");
      beat(SQ,  32'h14, B_INCR4, 1, 0, H_NONE, "R3");

      // fixed burst, BUSY turning into NONSEQ is illegal (R2), then sticky (R10)
      restart();
      beat(NSQ, 32'h20, B_INCR4, 1, 0, H_NONE, "R2");
      beat(BSY, 32'h24, B_INCR4, 0, 0, H_NONE, "R2");
      beat(NSQ, 32'h40, B_INCR4, 0, 0, H_TY,   "R2");
      beat(NSQ, 32'h40, B_INCR4, 1, 0, H_NONE, "R10");
      beat(IDL, 32'h0,  B_SINGLE, 1, 0, H_NONE, "R10");

      // stalled NONSEQ changing type, twice (R4, R10)
      restart();
      beat(NSQ, 32'h100, B_SINGLE, 0, 0, H_NONE, "R4");
      beat(SQ,  32'h100, B_SINGLE, 0, 0, H_TY,   "R4");
      beat(IDL, 32'h100, B_SINGLE, 1, 0, H_TY,   "R10");
      beat(IDL, 32'h100, B_SINGLE, 1, 0, H_NONE, "R10");

      // stalled NONSEQ moving its address (R5)
      restart();
      beat(IDL, 32'h0,   B_SINGLE, 0, 0, H_NONE, "R5");
      beat(NSQ, 32'h200, B_SINGLE, 0, 0, H_NONE, "R5");
      beat(NSQ, 32'h204, B_SINGLE, 0, 0, H_AD,   "R5");
      beat(NSQ, 32'h204, B_SINGLE, 1, 0, H_NONE, "R5");

      // IDLE address roams freely while stalled (R7)
      restart();
      beat(IDL, 32'h10, B_SINGLE, 0, 0, H_NONE, "R7");
      beat(IDL, 32'h20, B_SINGLE, 0, 0, H_NONE, "R7");
      beat(IDL, 32'h30, B_SINGLE, 0, 0, H_NONE, "R7");
      beat(NSQ, 32'h34, B_SINGLE, 0, 0, H_NONE, "R7");
      beat(NSQ, 32'h34, B_SINGLE, 1, 0, H_NONE, "R7");

      // BUSY address changes: one allowed, the second flagged, count cleared (R6)
      restart();
      beat(NSQ, 32'h300, B_INCR, 1, 0, H_NONE, "R6");
      beat(BSY, 32'h304, B_INCR, 0, 0, H_NONE, "R6");
      beat(BSY, 32'h308, B_INCR, 0, 0, H_NONE, "R6");
      beat(BSY, 32'h30C, B_INCR, 0, 0, H_AD,   "R6");
      beat(BSY, 32'h30C, B_INCR, 1, 0, H_NONE, "R6");
      beat(BSY, 32'h310, B_INCR, 0, 0, H_NONE, "R6");
      beat(BSY, 32'h314, B_INCR, 0, 0, H_NONE, "R6");
      beat(SQ,  32'h314, B_INCR, 1, 0, H_NONE, "R6");

      // ERROR response exempts the following change (R8)
      restart();
      beat(NSQ, 32'h400, B_INCR, 1, 0, H_NONE, "R8");
      beat(SQ,  32'h404, B_INCR, 0, 0, H_NONE, "R8");
      beat(SQ,  32'h404, B_INCR, 0, 1, H_NONE, "R8");
      beat(IDL, 32'h500, B_SINGLE, 1, 1, H_NONE, "R8");
      beat(IDL, 32'h500, B_SINGLE, 1, 0, H_NONE, "R8");

      // SEQ address must match preceding BUSY (R9), flag persists (R10)
      restart();
      beat(NSQ, 32'h600, B_INCR, 1, 0, H_NONE, "R9");
      beat(BSY, 32'h604, B_INCR, 1, 0, H_NONE, "R9");
      beat(SQ,  32'h608, B_INCR, 1, 0, H_SQ,   "R9");
      beat(IDL, 32'h0,   B_SINGLE, 1, 0, H_NONE, "R10");
      beat(IDL, 32'h0,   B_SINGLE, 1, 0, H_NONE, "R10");

      // burst kind latched at accepted NONSEQ only (R11)
      restart();
      beat(NSQ, 32'h700, B_INCR4, 0, 0, H_NONE, "R11");
      beat(NSQ, 32'h700, B_INCR4, 1, 0, H_NONE, "R11");
      beat(BSY, 32'h704, B_INCR,  0, 0, H_NONE, "R11");
      beat(IDL, 32'h704, B_INCR,  0, 0, H_TY,   "R11");
      beat(IDL, 32'h704, B_INCR,  1, 0, H_NONE, "R11");

      // reset clears everything again (R1)
      restart();
      beat(IDL, 32'h0, B_SINGLE, 1, 0, H_NONE, "R1");

      wait (sb_q.size() == 0);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule